// File: doc/BRIEF.md
# Two-Tone Frequency Discriminator

This block watches a single-bit square-wave input and reports which of two frequency bands the tone belongs to. A two-stage synchronizer brings the tone into the clock domain. Each high pulse is then timed in system-clock cycles. When the pulse ends, its width is sorted into one of three groups. Short pulses come from the high-frequency band and drive the decision low. Long pulses come from the low-frequency band and drive it high. Widths that fall in the guard band between the two limits keep the previous decision, which gives the block hysteresis.

All limits are counts of clock cycles. The defaults assume a 250 MHz clock. With those defaults, tones above 4.5 kHz read as high-band and tones below 1.6 kHz read as low-band. A midpoint count near 2.7 kHz settles the first pulse after reset when that pulse lands in the guard band. The counter is wide enough to cover tones down to 0.625 kHz, and it saturates instead of wrapping. The decision and its valid flag are plain levels. There is no handshake and no back-pressure: a consumer samples them whenever it wants, and `band_valid` tells it whether a pulse has been measured since reset.

Top module: `tone_discriminator`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it is released, `band_low` and `band_valid` are both 0.
- R2: A pulse whose width is no more than SHORT_MAX cycles sets `band_low` to 0 (high-frequency tone). A width of exactly SHORT_MAX counts as short.
- R3: A pulse whose width is at least LONG_MIN cycles sets `band_low` to 1 (low-frequency tone). A width of exactly LONG_MIN counts as long.
- R4: Once `band_valid` is 1, a pulse whose width is strictly between SHORT_MAX and LONG_MIN leaves `band_low` unchanged.
- R5: For the first pulse after reset, a width in the guard band sets `band_low` to 1 if the width exceeds MID_CNT, and to 0 otherwise.
- R6: `band_valid` rises when the first complete pulse after reset has been measured. It then stays 1 until the next reset.
- R7: `band_low` changes only on the second rising clock edge after `tone_in` falls. It holds its value while the tone stays high and while it stays low.
- R8: The pulse width is the number of rising clock edges at which `tone_in` was sampled high. The count saturates at 2^CNT_W-1 rather than wrapping, so an over-long pulse still reads as long.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tone_in | input | 1 | Asynchronous square-wave tone |
| band_low | output | 1 | 1 for the low-frequency band, 0 for the high-frequency band |
| band_valid | output | 1 | 1 once a full pulse has been measured since reset |

## Verification
The bench places pulses exactly on SHORT_MAX, SHORT_MAX+1, LONG_MIN-1 and LONG_MIN:
- An off-by-one comparison would flip the decision at one of these edges.
- A design without hysteresis would move the output on guard-band pulses.

It also checks the following cases:
- **Guard-band first pulse after reset.** It sends one such pulse on each side of the midpoint. A design that ignored the midpoint would leave the output low in the case where it should go high.
- **Over-long pulse.** It sends a pulse longer than the counter range. A wrapping counter would then report a short or guard-band width.
- **Decision timing.** It samples the output one edge and two edges after a falling input, and once in the middle of a long pulse. A design that classified the running count, or that had the wrong latency, would change the output at the wrong time.

// File: rtl/tone_pkg.sv
package tone_pkg;

  typedef enum logic [1:0] {
    WIDTH_SHORT = 2'd0,
    WIDTH_GUARD = 2'd1,
    WIDTH_LONG  = 2'd2
  } width_class_e;

  // Sort a measured pulse width against the two band limits.
  function automatic width_class_e sort_width(input int w, input int short_max,
                                              input int long_min);
    if (w <= short_max)     return WIDTH_SHORT;
    else if (w >= long_min) return WIDTH_LONG;
    else                    return WIDTH_GUARD;
  endfunction

endpackage

// File: rtl/tone_sync.sv
module tone_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic stage1,
  output logic stage2
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage1 <= 1'b0;
      stage2 <= 1'b0;
    end else begin
      stage1 <= async_in;
      stage2 <= stage1;
    end
  end
endmodule

// File: rtl/tone_pulse_meter.sv
module tone_pulse_meter #(
  parameter int CNT_W = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lvl_new,   // first synchronizer stage
  input  logic             lvl_cur,   // second synchronizer stage
  output logic             fall_stb,  // last high cycle of a pulse
  output logic [CNT_W-1:0] width      // width including this cycle
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] run_cnt;

  assign fall_stb = lvl_cur & ~lvl_new;
  assign width    = (run_cnt == CNT_MAX) ? CNT_MAX : run_cnt + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n)                  run_cnt <= '0;
    else if (!lvl_cur || fall_stb) run_cnt <= '0;
    else                         run_cnt <= width;
  end
endmodule

// File: rtl/tone_band_decider.sv
module tone_band_decider
  import tone_pkg::*;
#(
  parameter int CNT_W     = 18,
  parameter int SHORT_MAX = 27778,
  parameter int MID_CNT   = 46296,
  parameter int LONG_MIN  = 78125
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fall_stb,
  input  logic [CNT_W-1:0] width,
  output logic             band_low,
  output logic             band_valid
);
  width_class_e cls;
  logic         next_low;

  always_comb begin
    cls = sort_width(int'(width), SHORT_MAX, LONG_MIN);
    unique case (cls)
      WIDTH_SHORT: next_low = 1'b0;
      WIDTH_LONG:  next_low = 1'b1;
      default:     next_low = band_valid ? band_low : (int'(width) > MID_CNT);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      band_low   <= 1'b0;
      band_valid <= 1'b0;
    end else if (fall_stb) begin
      band_low   <= next_low;
      band_valid <= 1'b1;
    end
  end
endmodule

// File: rtl/tone_discriminator.sv
module tone_discriminator #(
  parameter int CNT_W     = 18,
  parameter int SHORT_MAX = 27778,
  parameter int MID_CNT   = 46296,
  parameter int LONG_MIN  = 78125
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tone_in,
  output logic band_low,
  output logic band_valid
);
  logic             sync_a;
  logic             sync_b;
  logic             fall_stb;
  logic [CNT_W-1:0] width;

  tone_sync u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(tone_in),
    .stage1(sync_a), .stage2(sync_b)
  );

  tone_pulse_meter #(.CNT_W(CNT_W)) u_meter (
    .clk(clk), .rst_n(rst_n), .lvl_new(sync_a), .lvl_cur(sync_b),
    .fall_stb(fall_stb), .width(width)
  );

  tone_band_decider #(
    .CNT_W(CNT_W), .SHORT_MAX(SHORT_MAX), .MID_CNT(MID_CNT), .LONG_MIN(LONG_MIN)
  ) u_decide (
    .clk(clk), .rst_n(rst_n), .fall_stb(fall_stb), .width(width),
    .band_low(band_low), .band_valid(band_valid)
  );
endmodule

// File: rtl/tone_discriminator_chk.sv
module tone_discriminator_chk #(
  parameter int CNT_W     = 18,
  parameter int SHORT_MAX = 27778,
  parameter int LONG_MIN  = 78125
) (
  input logic             clk,
  input logic             rst_n,
  input logic             fall_stb,
  input logic [CNT_W-1:0] width,
  input logic             band_low,
  input logic             band_valid
);
  assert_short_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_stb && int'(width) <= SHORT_MAX) |=> !band_low);

  assert_long_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_stb && int'(width) >= LONG_MIN) |=> band_low);

  assert_guard_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_stb && band_valid && int'(width) > SHORT_MAX && int'(width) < LONG_MIN)
      |=> $stable(band_low));

  assert_valid_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    band_valid |=> band_valid);

  assert_quiet_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !fall_stb |=> ($stable(band_low) && $stable(band_valid)));

  assert_width_nonzero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fall_stb |-> (width != '0));
endmodule

bind tone_discriminator tone_discriminator_chk #(
  .CNT_W(CNT_W), .SHORT_MAX(SHORT_MAX), .LONG_MIN(LONG_MIN)
) u_chk (
  .clk(clk), .rst_n(rst_n), .fall_stb(fall_stb), .width(width),
  .band_low(band_low), .band_valid(band_valid)
);

// File: tb/sim_tone_discriminator.sv
`timescale 1ns/1ps
module sim_tone_discriminator;
  localparam int CNT_W = 8;
  localparam int SMAX  = 20;
  localparam int MID   = 40;
  localparam int LMIN  = 60;
  localparam int NV    = 12;

  // Table: pulse width, expected band_low afterwards.
  localparam int VW[NV] = '{70, 30, 50, 20, 21, 59, 60, 5, 1, 100, 45, 41};
  localparam bit VE[NV] = '{1,  1,  1,  0,  0,  0,  1,  0, 0, 1,   1,  1};
  // rows: R3, R4, R4, R2 edge, R4 edge, R4 edge, R3 edge, R2, R2/R8, R3, R4, R4

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tone_in = 1'b0;
  logic band_low, band_valid;
  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  tone_discriminator #(
    .CNT_W(CNT_W), .SHORT_MAX(SMAX), .MID_CNT(MID), .LONG_MIN(LMIN)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .tone_in(tone_in),
    .band_low(band_low), .band_valid(band_valid)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    tone_in = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic pulse(input int w);
    @(negedge clk);
    tone_in = 1'b1;
    repeat (w) @(negedge clk);
    tone_in = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1: reset state, just after release
    check("R1 low", band_low, 1'b0);
    check("R1 valid", band_valid, 1'b0);

    // R5: first pulse in guard band below midpoint -> 0; R6 valid rises
    pulse(30);
    check("R5 below mid", band_low, 1'b0);
    check("R6 valid", band_valid, 1'b1);

    // Table walk
    for (int i = 0; i < NV; i++) begin
      pulse(VW[i]);
      check($sformatf("table row %0d", i), band_low, VE[i]);
    end

    // R7: latency of exactly two edges after fall (current state 1 -> short pulse)
    @(negedge clk);
    tone_in = 1'b1;
    repeat (5) @(negedge clk);
    tone_in = 1'b0;
    @(negedge clk);
    check("R7 one edge", band_low, 1'b1);
    @(negedge clk);
    check("R7 two edges", band_low, 1'b0);
    repeat (4) @(negedge clk);

    // R7: held during a long high phase; R8 saturation reads as long
    @(negedge clk);
    tone_in = 1'b1;
    repeat (150) @(negedge clk);
    check("R7 hold while high", band_low, 1'b0);
    repeat (150) @(negedge clk);
    tone_in = 1'b0;
    repeat (6) @(negedge clk);
    check("R8 saturate 300", band_low, 1'b1);
    check("R6 valid stays", band_valid, 1'b1);

    // R8: 270 would wrap to a short width
    pulse(5);
    pulse(270);
    check("R8 saturate 270", band_low, 1'b1);

    // R1: reset clears a high decision
    do_reset();
    check("R1 low after set", band_low, 1'b0);
    check("R1 valid after set", band_valid, 1'b0);

    // R5: first pulse above midpoint -> 1
    pulse(50);
    check("R5 above mid", band_low, 1'b1);
    check("R6 valid again", band_valid, 1'b1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule